// File: doc/BRIEF.md
# Reset Pin Monitor

This block watches an external active-low reset pin from inside the master clock domain. The raw pin goes through a chain of flip-flops to resynchronize it. The synchronized level is offered as a status bit. A falling edge of that level sets a sticky event flag, which stays set until software reads the status. The block also raises an interrupt for the event, but only when the pin is not itself configured to reset the chip and the interrupt is enabled.

The surrounding controller supplies a one-cycle status-read strobe whenever its status word is read. It also supplies the two configuration bits. Address decoding and the generation of the actual reset both sit outside this block. All state resets synchronously on an active-high reset. During that reset the synchronizer chain is loaded with the inactive (high) pin level.

Top module: `rstpin_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the level output is 1, the event flag is 0 and the interrupt is 0.
- R2: The level output equals the raw pin value that was sampled SYNC_STAGES rising edges earlier. The default is 2.
- R3: A 1-to-0 change of the level output sets the event flag on the next rising edge. For the default of 2 stages, the flag is 1 after the third edge that follows the pin going low.
- R4: A 0-to-1 change of the level output never sets the event flag.
- R5: The flag clears at a rising edge where the status-read strobe is 1, unless a new falling edge sets it in that same edge.
- R6: A falling edge that coincides with a status read leaves the flag at 1.
- R7: The interrupt is 1 exactly when the flag is 1, the user-reset enable is 0 and the interrupt enable is 1. It follows those inputs in the same cycle, so it drops in the cycle the flag clears.
- R8: Once set, the flag holds through any further pin activity until a status read.
- R9: If the pin is held high through reset and afterwards, the flag never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 1 | Raw external active-low reset pin |
| ureset_en | input | 1 | 1: pin is configured to cause a reset (interrupt suppressed) |
| irq_en | input | 1 | Interrupt enable |
| sr_rd | input | 1 | One-cycle status-read strobe |
| pin_level | output | 1 | Synchronized pin level |
| fall_flag | output | 1 | Sticky falling-edge event flag |
| irq | output | 1 | Event interrupt |

## Verification
Directed sequences separate three cases: a falling edge, a rising edge and a pin held steady. They show that only the falling transition sets the flag, and that it does so on the expected edge counted from the pin change. A coincident read and falling edge tells set-wins priority apart from clear-wins priority. All four combinations of the two enable bits show that the interrupt depends on each bit. A long pseudo-random sweep of pin, read strobe and enables then compares every output, every cycle, against a cycle model in the bench. This catches latency errors and lost or spurious events.

// File: rtl/rstpin_monitor_pkg.sv
package rstpin_monitor_pkg;
  localparam int unsigned RPM_SYNC_STAGES_DEF = 2;
  localparam logic        RPM_PIN_IDLE        = 1'b1;
endpackage

// File: rtl/rpm_pin_sync.sv
module rpm_pin_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= IDLE;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= IDLE;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[LAST];
endmodule

// File: rtl/rpm_fall_flag.sv
module rpm_fall_flag #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic clr,
  output logic flag
);
  logic level_q;
  logic fell;

  // level_q trails the synchronized level by one edge
  always_ff @(posedge clk) begin
    if (rst) level_q <= IDLE;
    else     level_q <= level;
  end

  assign fell = level_q & ~level;

  // set has priority over the read clear
  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (fell) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/rstpin_monitor.sv
module rstpin_monitor
  import rstpin_monitor_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = RPM_SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic ureset_en,
  input  logic irq_en,
  input  logic sr_rd,
  output logic pin_level,
  output logic fall_flag,
  output logic irq
);
  logic lvl_s;
  logic flg_s;

  rpm_pin_sync #(
    .STAGES (SYNC_STAGES),
    .IDLE   (RPM_PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_n),
    .dout (lvl_s)
  );

  rpm_fall_flag #(
    .IDLE (RPM_PIN_IDLE)
  ) u_flag (
    .clk   (clk),
    .rst   (rst),
    .level (lvl_s),
    .clr   (sr_rd),
    .flag  (flg_s)
  );

  assign pin_level = lvl_s;
  assign fall_flag = flg_s;
  assign irq       = flg_s & ~ureset_en & irq_en;
endmodule

// File: rtl/rstpin_monitor_chk.sv
module rstpin_monitor_chk (
  input logic clk,
  input logic rst,
  input logic ureset_en,
  input logic irq_en,
  input logic sr_rd,
  input logic pin_level,
  input logic fall_flag,
  input logic irq
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk) rst |=> (pin_level && !fall_flag && !irq));
  // R3 and R6: a fall sets the flag even when a read is present
  a_r3_fall_sets: assert property (@(posedge clk) disable iff (rst) $fell(pin_level) |=> fall_flag);
  // R4: without a fall the flag cannot rise
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!fall_flag && !$fell(pin_level)) |=> !fall_flag);
  // R5
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (sr_rd && !$fell(pin_level)) |=> !fall_flag);
  // R8
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (fall_flag && !sr_rd) |=> fall_flag);
  // R7
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (fall_flag && irq_en && !ureset_en));
  a_r7_irq_fires: assert property (@(posedge clk) disable iff (rst)
    (fall_flag && irq_en && !ureset_en) |-> irq);
endmodule

bind rstpin_monitor rstpin_monitor_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ureset_en (ureset_en),
  .irq_en    (irq_en),
  .sr_rd     (sr_rd),
  .pin_level (pin_level),
  .fall_flag (fall_flag),
  .irq       (irq)
);

// File: tb/rstpin_monitor_test.sv
module rstpin_monitor_test;
  localparam int unsigned STG = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_n = 1'b1;
  logic ureset_en = 1'b0;
  logic irq_en = 1'b1;
  logic sr_rd = 1'b0;
  logic pin_level, fall_flag, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rstpin_monitor #(.SYNC_STAGES(STG)) uut (
    .clk(clk), .rst(rst), .pin_n(pin_n), .ureset_en(ureset_en),
    .irq_en(irq_en), .sr_rd(sr_rd), .pin_level(pin_level),
    .fall_flag(fall_flag), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %b expected %b", req, cyc, got, exp);
    end
  endtask

  // bench model state
  logic [STG-1:0] m_sync;
  logic m_prev, m_flag;

  task automatic model_reset();
    m_sync = '1;
    m_prev = 1'b1;
    m_flag = 1'b0;
  endtask

  // advances the model by one edge using the inputs that are currently driven
  task automatic model_edge();
    logic lvl;
    lvl = m_sync[STG-1];
    m_flag = (m_prev & ~lvl) | (m_flag & ~sr_rd);
    m_prev = lvl;
    m_sync = {m_sync[STG-2:0], pin_n};
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    @(negedge clk);
    // R1: during reset
    step(); step();
    chk("R1 level", pin_level, 1'b1);
    chk("R1 flag", fall_flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
    rst = 1'b0;
    step();
    chk("R1 level after release", pin_level, 1'b1);
    chk("R1 flag after release", fall_flag, 1'b0);
    // R9: pin idle high
    for (int i = 0; i < 5; i++) step();
    chk("R9 no flag with idle pin", fall_flag, 1'b0);

    // R2 / R3: falling pin
    pin_n = 1'b0;
    step();
    chk("R2 level after one edge", pin_level, 1'b1);
    step();
    chk("R2 level after two edges", pin_level, 1'b0);
    chk("R3 flag not yet set", fall_flag, 1'b0);
    step();
    chk("R3 flag set third edge", fall_flag, 1'b1);

    // R7: all enable combinations
    for (int k = 0; k < 4; k++) begin
      ureset_en = k[1];
      irq_en = k[0];
      #1;
      chk("R7 irq gating", irq, (!k[1]) && k[0]);
    end
    ureset_en = 1'b0; irq_en = 1'b1; #1;

    // R8: more pin activity without read
    pin_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    pin_n = 1'b0;
    for (int i = 0; i < 4; i++) step();
    chk("R8 flag held", fall_flag, 1'b1);

    // R5: read clears, irq drops with it
    sr_rd = 1'b1;
    step();
    sr_rd = 1'b0;
    chk("R5 flag cleared by read", fall_flag, 1'b0);
    chk("R7 irq drops with flag", irq, 1'b0);

    // R4: rising pin does not set
    pin_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    chk("R4 rising edge ignored", fall_flag, 1'b0);
    chk("R2 level high again", pin_level, 1'b1);

    // R6: fall coinciding with read; flag first set then refreshed
    pin_n = 1'b0;
    for (int i = 0; i < 3; i++) step();
    chk("R3 flag set before coincidence", fall_flag, 1'b1);
    pin_n = 1'b1;
    for (int i = 0; i < 3; i++) step();
    pin_n = 1'b0;
    step(); step();
    chk("R2 level just fell", pin_level, 1'b0);
    sr_rd = 1'b1;
    step();
    sr_rd = 1'b0;
    chk("R6 set wins over read", fall_flag, 1'b1);
    sr_rd = 1'b1;
    step();
    sr_rd = 1'b0;
    chk("R5 plain read clears", fall_flag, 1'b0);

    // randomized sweep against the model, starting from a fresh reset
    pin_n = 1'b1;
    rst = 1'b1;
    step();
    rst = 1'b0;
    model_reset();
    lfsr = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) pin_n = ~pin_n;
      sr_rd = (lfsr[7:4] == 4'd3);
      ureset_en = n[9];
      irq_en = n[8];
      model_edge();
      step();
      chk("R2 sweep level", pin_level, m_sync[STG-1]);
      chk("R3 R5 sweep flag", fall_flag, m_flag);
      chk("R7 sweep irq", irq, m_flag & ~ureset_en & irq_en);
    end
    sr_rd = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule